// File: doc/BRIEF.md
# CCD Vertical Transfer Sequencer with Center-Cut Sweep

This block drives the three vertical transfer phases of an interline CCD for one of three readout modes: full progressive frames, or one of two center-cut modes that keep a band of lines from the middle of the array. It counts lines on the horizontal sync pulse from the line timer and counts pixel clocks inside each line. A frame begins on the vertical sync pulse, which must arrive together with a horizontal sync pulse.

Each frame runs through a fixed order of phases. First comes a fast sweep that throws away the unwanted top lines. Then one line carries the request that moves charge out of the photodiodes. A fast frame shift follows, and then the kept window is output one line at a time. After that the block waits for the next vertical sync. In the progressive mode the sweep and the shift are both empty.

A fast burst fits a given number of three-phase steps into a given number of line periods. The defaults are 167 steps in 16 lines and 142 steps in 14 lines for the 222-line window, and 255 steps in 24 lines and 215 steps in 20 lines for the 76-line window. At 780 pixel clocks per line, each of these gives 12 clocks per sub-state. During the kept window, each line gets a single step inside its horizontal blanking interval.

Top module: `ccdv_sweep_seq`

## Requirements
- R1: After reset, and until the first vertical sync, the phase outputs hold the rest pattern {v1,v2,v3}=100 and readout_req and line_valid are low.
- R2: A step moves the phases through six sub-states in the order 110, 010, 011, 001, 101, 100. The pattern stays at 100 between steps. From one sub-state to the next, exactly one phase changes.
- R3: The mode input is sampled only on the clock where vd is high. The encodings are 00 progressive, 01 first center mode and 10 second center mode, and 11 behaves as 00. Changes to mode at any other time have no effect on the current frame.
- R4: Lines counted from vsync (line 0) follow this order: sweep lines, one readout line, shift lines, window lines, then idle. The progressive mode has no sweep lines and no shift lines.
- R5: A burst of N steps over L lines uses sub-states of S = floor((L*LINE_CLKS-1)/(6*N)) clocks each. The steps run back to back from pixel 1 of the burst's first line, and every step ends before the burst's last line ends.
- R6: Each window line issues one step, starting at pixel HB_START+1, with sub-states of LINE_SUB clocks each.
- R7: readout_req is high on pixels RD_START to RD_START+RD_LEN-1 of the readout line, and at no other time. During that line the phases stay at 100. Pixel 0 is the clock after the hsync is sampled.
- R8: line_valid is high for exactly the window lines. It is low during sweep, readout, shift and idle lines.
- R9: A vsync that arrives mid-frame abandons any step in progress. The phases show 100 on the next clock and a new frame begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vd | input | 1 | Frame start pulse, coincident with hd |
| hd | input | 1 | Line start pulse from the line timer |
| mode | input | 2 | Readout mode select |
| v1 | output | 1 | Vertical phase 1 level |
| v2 | output | 1 | Vertical phase 2 level |
| v3 | output | 1 | Vertical phase 3 level |
| readout_req | output | 1 | Photodiode readout request |
| line_valid | output | 1 | Current line belongs to the kept window |

## Verification
The bench builds the block with 60-clock lines, and scales the sweeps, shifts and windows down to a handful of lines. The burst counts are chosen so that the sub-state lengths come out to 5 or 6 clocks, and so that the floor division leaves slack before the burst ends. With these values every mode fits in about a thousand clocks, so a single run covers many whole frames, frames cut short in the middle of a burst, and mode changes in the middle of a frame.

// File: rtl/ccdv_pkg.sv
`timescale 1ns/1ps
package ccdv_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SWEEP = 3'd1,
    PH_READ  = 3'd2,
    PH_SHIFT = 3'd3,
    PH_OUT   = 3'd4
  } phase_t;

  localparam int SUBSTATES = 6;

  // Phase levels {v1,v2,v3} for each sub-state; state 0 is the rest pattern.
  function automatic logic [2:0] phase_pattern(input logic [2:0] st);
    case (st)
      3'd1:    return 3'b110;
      3'd2:    return 3'b010;
      3'd3:    return 3'b011;
      3'd4:    return 3'b001;
      3'd5:    return 3'b101;
      default: return 3'b100;
    endcase
  endfunction

  // Sub-state length that keeps all steps inside the burst window.
  function automatic int step_sub_len(input int lines, input int steps, input int line_clks);
    if (steps <= 0) return 1;
    return (lines * line_clks - 1) / (SUBSTATES * steps);
  endfunction

endpackage

// File: rtl/ccdv_step_gen.sv
`timescale 1ns/1ps
module ccdv_step_gen
  import ccdv_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             go,
  input  logic [CNT_W-1:0] n_steps,
  input  logic [CNT_W-1:0] sub_len,
  output logic             busy,
  output logic [2:0]       st
);

  logic [CNT_W-1:0] sc;
  logic [CNT_W-1:0] left;
  logic [CNT_W-1:0] sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      st    <= 3'd0;
      sc    <= '0;
      left  <= '0;
      sub_q <= '0;
    end else if (clr) begin
      busy <= 1'b0;
      st   <= 3'd0;
      sc   <= '0;
      left <= '0;
    end else if (go) begin
      busy  <= 1'b1;
      st    <= 3'd1;
      sub_q <= sub_len;
      sc    <= sub_len - 1'b1;
      left  <= n_steps - 1'b1;
    end else if (busy) begin
      if (sc != '0) begin
        sc <= sc - 1'b1;
      end else begin
        sc <= sub_q - 1'b1;
        if (st == 3'd0) begin
          if (left == '0) begin
            busy <= 1'b0;
          end else begin
            left <= left - 1'b1;
            st   <= 3'd1;
          end
        end else begin
          st <= (st == 3'd5) ? 3'd0 : st + 3'd1;
        end
      end
    end
  end

  // R2
  one_phase_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && st != $past(st)) |->
      $countones(phase_pattern(st) ^ phase_pattern($past(st))) == 1);

  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!busy || clr));

endmodule

// File: rtl/ccdv_frame_ctl.sv
`timescale 1ns/1ps
module ccdv_frame_ctl
  import ccdv_pkg::*;
#(
  parameter int LINE_CLKS      = 780,
  parameter int CNT_W          = 12,
  parameter int PROG_OUT       = 494,
  parameter int C1_SWEEP_LINES = 16,
  parameter int C1_SWEEP_STEPS = 167,
  parameter int C1_SHIFT_LINES = 14,
  parameter int C1_SHIFT_STEPS = 142,
  parameter int C1_OUT         = 222,
  parameter int C2_SWEEP_LINES = 24,
  parameter int C2_SWEEP_STEPS = 255,
  parameter int C2_SHIFT_LINES = 20,
  parameter int C2_SHIFT_STEPS = 215,
  parameter int C2_OUT         = 76,
  localparam int PIX_W         = $clog2(LINE_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vd,
  input  logic             hd,
  input  logic [1:0]       mode,
  output phase_t           ph,
  output logic [PIX_W-1:0] pix,
  output logic             burst_go,
  output logic [CNT_W-1:0] burst_steps,
  output logic [CNT_W-1:0] burst_sub
);

  logic [1:0]       mode_q;
  logic [1:0]       mode_f;
  logic [CNT_W-1:0] lcnt;
  logic [CNT_W-1:0] lcnt_nxt;
  phase_t           ph_nxt;
  logic             enter;
  int               b_lines;
  int               b_steps;

  function automatic int sweep_lines(input logic [1:0] m);
    case (m)
      2'd1:    return C1_SWEEP_LINES;
      2'd2:    return C2_SWEEP_LINES;
      default: return 0;
    endcase
  endfunction

  function automatic int sweep_steps(input logic [1:0] m);
    case (m)
      2'd1:    return C1_SWEEP_STEPS;
      2'd2:    return C2_SWEEP_STEPS;
      default: return 0;
    endcase
  endfunction

  function automatic int shift_lines(input logic [1:0] m);
    case (m)
      2'd1:    return C1_SHIFT_LINES;
      2'd2:    return C2_SHIFT_LINES;
      default: return 0;
    endcase
  endfunction

  function automatic int shift_steps(input logic [1:0] m);
    case (m)
      2'd1:    return C1_SHIFT_STEPS;
      2'd2:    return C2_SHIFT_STEPS;
      default: return 0;
    endcase
  endfunction

  function automatic int out_lines(input logic [1:0] m);
    case (m)
      2'd1:    return C1_OUT;
      2'd2:    return C2_OUT;
      default: return PROG_OUT;
    endcase
  endfunction

  function automatic int phase_lines(input phase_t p, input logic [1:0] m);
    case (p)
      PH_SWEEP: return sweep_lines(m);
      PH_READ:  return 1;
      PH_SHIFT: return shift_lines(m);
      PH_OUT:   return out_lines(m);
      default:  return 0;
    endcase
  endfunction

  function automatic phase_t phase_after(input phase_t p, input logic [1:0] m);
    case (p)
      PH_SWEEP: return PH_READ;
      PH_READ:  return (shift_lines(m) != 0) ? PH_SHIFT : PH_OUT;
      PH_SHIFT: return PH_OUT;
      default:  return PH_IDLE;
    endcase
  endfunction

  assign mode_f = (mode == 2'b11) ? 2'b00 : mode;

  always_comb begin
    enter    = 1'b0;
    ph_nxt   = ph;
    lcnt_nxt = lcnt;
    if (vd) begin
      enter    = 1'b1;
      ph_nxt   = (sweep_lines(mode_f) != 0) ? PH_SWEEP : PH_READ;
      lcnt_nxt = '0;
    end else if (hd && ph != PH_IDLE) begin
      if (int'(lcnt) + 1 >= phase_lines(ph, mode_q)) begin
        enter    = 1'b1;
        ph_nxt   = phase_after(ph, mode_q);
        lcnt_nxt = '0;
      end else begin
        lcnt_nxt = lcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      lcnt     <= '0;
      mode_q   <= 2'b00;
      burst_go <= 1'b0;
      pix      <= '0;
    end else begin
      ph       <= ph_nxt;
      lcnt     <= lcnt_nxt;
      burst_go <= enter && (ph_nxt == PH_SWEEP || ph_nxt == PH_SHIFT);
      if (vd) mode_q <= mode_f;
      if (hd) pix <= '0;
      else if (pix != PIX_W'(LINE_CLKS)) pix <= pix + 1'b1;
    end
  end

  always_comb begin
    case (ph)
      PH_SWEEP: begin b_lines = sweep_lines(mode_q); b_steps = sweep_steps(mode_q); end
      PH_SHIFT: begin b_lines = shift_lines(mode_q); b_steps = shift_steps(mode_q); end
      default:  begin b_lines = 0;                   b_steps = 0;                   end
    endcase
  end

  assign burst_steps = CNT_W'(b_steps);
  assign burst_sub   = CNT_W'(step_sub_len(b_lines, b_steps, LINE_CLKS));

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vd) |-> $stable(mode_q));

endmodule

// File: rtl/ccdv_sweep_seq.sv
`timescale 1ns/1ps
module ccdv_sweep_seq
  import ccdv_pkg::*;
#(
  parameter int LINE_CLKS      = 780,
  parameter int CNT_W          = 12,
  parameter int PROG_OUT       = 494,
  parameter int C1_SWEEP_LINES = 16,
  parameter int C1_SWEEP_STEPS = 167,
  parameter int C1_SHIFT_LINES = 14,
  parameter int C1_SHIFT_STEPS = 142,
  parameter int C1_OUT         = 222,
  parameter int C2_SWEEP_LINES = 24,
  parameter int C2_SWEEP_STEPS = 255,
  parameter int C2_SHIFT_LINES = 20,
  parameter int C2_SHIFT_STEPS = 215,
  parameter int C2_OUT         = 76,
  parameter int HB_START       = 8,
  parameter int LINE_SUB       = 12,
  parameter int RD_START       = 20,
  parameter int RD_LEN         = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vd,
  input  logic       hd,
  input  logic [1:0] mode,
  output logic       v1,
  output logic       v2,
  output logic       v3,
  output logic       readout_req,
  output logic       line_valid
);

  localparam int PIX_W = $clog2(LINE_CLKS + 1);

  phase_t           ph;
  logic [PIX_W-1:0] pix;
  logic             burst_go;
  logic [CNT_W-1:0] burst_steps;
  logic [CNT_W-1:0] burst_sub;
  logic             line_go;
  logic             step_go;
  logic [CNT_W-1:0] step_n;
  logic [CNT_W-1:0] step_sub;
  logic             busy;
  logic [2:0]       st;

  ccdv_frame_ctl #(
    .LINE_CLKS(LINE_CLKS), .CNT_W(CNT_W), .PROG_OUT(PROG_OUT),
    .C1_SWEEP_LINES(C1_SWEEP_LINES), .C1_SWEEP_STEPS(C1_SWEEP_STEPS),
    .C1_SHIFT_LINES(C1_SHIFT_LINES), .C1_SHIFT_STEPS(C1_SHIFT_STEPS),
    .C1_OUT(C1_OUT),
    .C2_SWEEP_LINES(C2_SWEEP_LINES), .C2_SWEEP_STEPS(C2_SWEEP_STEPS),
    .C2_SHIFT_LINES(C2_SHIFT_LINES), .C2_SHIFT_STEPS(C2_SHIFT_STEPS),
    .C2_OUT(C2_OUT)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .vd(vd), .hd(hd), .mode(mode),
    .ph(ph), .pix(pix), .burst_go(burst_go),
    .burst_steps(burst_steps), .burst_sub(burst_sub)
  );

  assign line_go  = (ph == PH_OUT) && (pix == PIX_W'(HB_START));
  assign step_go  = burst_go | line_go;
  assign step_n   = burst_go ? burst_steps : CNT_W'(1);
  assign step_sub = burst_go ? burst_sub : CNT_W'(LINE_SUB);

  ccdv_step_gen #(.CNT_W(CNT_W)) u_step (
    .clk(clk), .rst_n(rst_n), .clr(vd), .go(step_go),
    .n_steps(step_n), .sub_len(step_sub), .busy(busy), .st(st)
  );

  assign {v1, v2, v3} = phase_pattern(st);
  assign readout_req  = (ph == PH_READ) && (int'(pix) >= RD_START) &&
                        (int'(pix) < RD_START + RD_LEN);
  assign line_valid   = (ph == PH_OUT);

  // R7
  readout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    readout_req |-> ({v1, v2, v3} == 3'b100 && !line_valid));

  // R5
  burst_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_READ || ph == PH_IDLE) |-> !busy);

endmodule

// File: tb/ccdv_sweep_seq_tb.sv
`timescale 1ns/1ps
module ccdv_sweep_seq_tb;

  localparam int LC  = 60;
  localparam int PO  = 12;
  localparam int S1L = 4, S1N = 7, H1L = 3, H1N = 5, O1 = 10;
  localparam int S2L = 5, S2N = 9, H2L = 4, H2N = 6, O2 = 6;
  localparam int HB  = 4, LS = 3, RDS = 10, RDL = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vd = 1'b0;
  logic hd = 1'b0;
  logic [1:0] mode = 2'b00;
  logic v1, v2, v3, readout_req, line_valid;

  int total = 0;
  int bad = 0;

  int    prev_m = 0, prev_ln = 0, prev_p = 0;
  bit    prev_live = 1'b0, have_prev = 1'b0;
  string prev_extra = "";

  always #10 clk = ~clk;

  ccdv_sweep_seq #(
    .LINE_CLKS(LC), .CNT_W(12), .PROG_OUT(PO),
    .C1_SWEEP_LINES(S1L), .C1_SWEEP_STEPS(S1N), .C1_SHIFT_LINES(H1L),
    .C1_SHIFT_STEPS(H1N), .C1_OUT(O1),
    .C2_SWEEP_LINES(S2L), .C2_SWEEP_STEPS(S2N), .C2_SHIFT_LINES(H2L),
    .C2_SHIFT_STEPS(H2N), .C2_OUT(O2),
    .HB_START(HB), .LINE_SUB(LS), .RD_START(RDS), .RD_LEN(RDL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .vd(vd), .hd(hd), .mode(mode),
    .v1(v1), .v2(v2), .v3(v3), .readout_req(readout_req), .line_valid(line_valid)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int frame_len(input int m);
    case (m)
      1:       return S1L + 1 + H1L + O1 + 1;
      2:       return S2L + 1 + H2L + O2 + 1;
      default: return 1 + PO + 1;
    endcase
  endfunction

  // Expected outputs at line ln (0 = vsync line), pixel p.
  function automatic void model(input int m, input int ln, input int p, input bit live,
                                output int ev, output bit erd, output bit elv,
                                output string seg);
    int sL = 0, sN = 0, hL = 0, hN = 0, oL = PO, st = 0, t = 0, sub = 1;
    bit a, b, c;
    erd = 1'b0; elv = 1'b0; seg = "R1";
    if (live) begin
      case (m)
        1: begin sL = S1L; sN = S1N; hL = H1L; hN = H1N; oL = O1; end
        2: begin sL = S2L; sN = S2N; hL = H2L; hN = H2N; oL = O2; end
        default: begin sL = 0; sN = 0; hL = 0; hN = 0; oL = PO; end
      endcase
      seg = "R4";
      if (ln < sL) begin
        seg = "R5";
        sub = (sL * LC - 1) / (6 * sN);
        t = ln * LC + p - 1;
        if (t >= 0 && t < sN * 6 * sub) st = ((t / sub) % 6 + 1) % 6;
      end else if (ln == sL) begin
        seg = "R7";
        erd = (p >= RDS) && (p < RDS + RDL);
      end else if (ln < sL + 1 + hL) begin
        seg = "R5";
        sub = (hL * LC - 1) / (6 * hN);
        t = (ln - sL - 1) * LC + p - 1;
        if (t >= 0 && t < hN * 6 * sub) st = ((t / sub) % 6 + 1) % 6;
      end else if (ln < sL + 1 + hL + oL) begin
        seg = "R6";
        elv = 1'b1;
        if (p > HB && p <= HB + 6 * LS) st = (((p - HB - 1) / LS) % 6 + 1) % 6;
      end
    end
    a = (st == 0) || (st == 1) || (st == 5);
    b = (st >= 1) && (st <= 3);
    c = (st >= 3);
    ev = (int'(a) << 2) | (int'(b) << 1) | int'(c);
  endfunction

  task automatic check_prev();
    int ev; bit erd, elv; string seg; int act;
    if (have_prev) begin
      model(prev_m, prev_ln, prev_p, prev_live, ev, erd, elv, seg);
      act = {29'd0, v1, v2, v3};
      chk(act == ev, {prev_extra, seg, " R2"}, "phases", act, ev);
      chk(readout_req == erd, {prev_extra, prev_live ? "R7" : "R1"}, "readout_req",
          int'(readout_req), int'(erd));
      chk(line_valid == elv, {prev_extra, prev_live ? "R8" : "R1"}, "line_valid",
          int'(line_valid), int'(elv));
    end
  endtask

  task automatic run_idle(input int nlines);
    for (int ln = 0; ln < nlines; ln++) begin
      for (int p = 0; p < LC; p++) begin
        @(negedge clk);
        check_prev();
        hd = (p == 0);
        vd = 1'b0;
        prev_live = 1'b0; prev_ln = ln; prev_p = p; prev_extra = ""; have_prev = 1'b1;
      end
    end
  endtask

  task automatic run_frame(input int m, input int nlines, input bit toggle,
                           input string first_tag);
    for (int ln = 0; ln < nlines; ln++) begin
      for (int p = 0; p < LC; p++) begin
        @(negedge clk);
        check_prev();
        hd = (p == 0);
        vd = (p == 0) && (ln == 0);
        if (ln == 0 && p == 0) mode = 2'(m);
        else if (toggle && p == 7) mode = 2'($urandom_range(0, 3)); // R3 ignored
        prev_m = m; prev_ln = ln; prev_p = p; prev_live = 1'b1; have_prev = 1'b1;
        prev_extra = toggle ? "R3 " : ((ln < 2) ? first_tag : "");
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int m, n;
    bit trunc, prev_trunc;
    void'($urandom(32'd4242));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({v1, v2, v3} == 3'b100, "R1", "phases in reset", {v1, v2, v3}, 4);
    chk(!readout_req && !line_valid, "R1", "flags in reset",
        {readout_req, line_valid}, 0);
    rst_n = 1'b1;
    run_idle(2);
    // R4 R5 R6 R7 R8: full frames in every mode, 11 aliases progressive (R3)
    run_frame(0, frame_len(0), 1'b0, "");
    run_frame(1, frame_len(1), 1'b0, "");
    run_frame(2, frame_len(2), 1'b0, "");
    run_frame(3, frame_len(3), 1'b0, "R3 ");
    // R9: restart in the middle of a sweep burst and in the middle of the window
    run_frame(1, 2, 1'b0, "");
    run_frame(2, frame_len(2), 1'b1, "R9 ");
    run_frame(0, 4, 1'b0, "");
    run_frame(1, frame_len(1), 1'b1, "R9 ");
    prev_trunc = 1'b0;
    for (int k = 0; k < 10; k++) begin
      m = $urandom_range(0, 3);
      trunc = ($urandom_range(0, 2) == 0);
      n = trunc ? $urandom_range(1, frame_len(m) - 1)
                : frame_len(m) + $urandom_range(0, 2);
      run_frame(m, n, 1'($urandom_range(0, 1)), prev_trunc ? "R9 " : "");
      prev_trunc = trunc;
    end
    @(negedge clk);
    check_prev();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule